// File: doc/BRIEF.md
# Wakeup and Issue Select Queue

This block is the scheduling window of an out-of-order core. Each entry holds one instruction that waits for its operands. The entry stores the instruction's sequence number, one producer tag per source operand, and a set of class flags. Producers announce completion by broadcasting their tag on the writeback ports. Every matching source in the window then becomes ready.

An entry can leave the window only when all of the following hold:
- every source is ready;
- no class hold is set (non-speculative, store-conditional, barrier, or waiting on a memory dependence);
- if it is a memory access that is not a prefetch, the data cache is not stalled.

Class holds are lifted one entry at a time through a release port, addressed by sequence number. Each cycle the oldest eligible entries are granted, up to the issue width. The granted entries leave the window at the next clock edge.

A squash removes every entry younger than a boundary sequence number. Those entries are also withheld from issue in the squash cycle itself. The block reports how many entries are waiting, how many of them are memory accesses, and whether the window is full.

Top module: `issue_queue`

## Requirements
- R1: After reset the window is empty: `wait_cnt` and `mem_cnt` are 0, `full` is 0 and no `iss_valid` lane is set.
- R2: An entry dispatched with all sources ready and no class hold is granted in the cycle that follows its dispatch edge, and then leaves the window.
- R3: An entry with unready sources is not granted until every one of its source tags has appeared on a valid writeback lane. It is granted in the cycle after the edge where its last source became ready.
- R4: A writeback tag that is broadcast in the same cycle as a dispatch marks the matching sources of the incoming entry ready.
- R5: `dis_cls` bits are: [5] memory access, [4] prefetch, [3] non-speculative, [2] store-conditional, [1] barrier, [0] memory-dependence wait. Any of bits [3:0] blocks issue even when all operands are ready. A `rel_valid` pulse with `rel_seq` equal to the entry's sequence number clears all four holds, and the entry is granted in the next cycle.
- R6: At most IW entries are granted per cycle. Grants go in increasing sequence-number order: lane 0 holds the oldest (smallest number), and no higher lane is valid without all lower lanes valid.
- R7: While `dc_stall` is 1, an entry with bit [5] set and bit [4] clear is not granted. Prefetches and non-memory entries still issue.
- R8: With `sq_valid` set, every entry whose sequence number is greater than `sq_seq` is removed at the edge and is not granted in that cycle. A dispatch in that cycle that is younger than the boundary is dropped. Older entries remain.
- R9: `full` is 1 exactly when DEPTH entries are waiting. A dispatch while full is ignored.
- R10: `wait_cnt` equals the number of waiting entries. `mem_cnt` equals the number of waiting entries that have bit [5] set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dis_valid | input | 1 | Dispatch an entry this cycle |
| dis_seq | input | SEQ_W | Sequence number of the dispatched entry |
| dis_tag | input | NSRC*SEQ_W | Producer tag per source |
| dis_rdy | input | NSRC | Source already ready at dispatch |
| dis_cls | input | 6 | Class flags (see R5) |
| full | output | 1 | No free slot |
| wb_valid | input | WB_N | Writeback lane valid |
| wb_tag | input | WB_N*SEQ_W | Writeback producer tag per lane |
| rel_valid | input | 1 | Clear class holds of one entry |
| rel_seq | input | SEQ_W | Sequence number to release |
| dc_stall | input | 1 | Data cache blocked |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Squash boundary; younger entries are removed |
| iss_valid | output | IW | Grant valid per lane |
| iss_seq | output | IW*SEQ_W | Granted sequence number per lane |
| wait_cnt | output | $clog2(DEPTH+1) | Waiting entries |
| mem_cnt | output | $clog2(DEPTH+1) | Waiting memory-access entries |

## Verification
The selection logic is exercised with several patterns:
- Single ready dispatches, where an entry is granted immediately.
- Two-source entries woken one tag at a time, which shows that a partially woken entry stays put.
- A same-cycle dispatch and writeback, which separates registered wakeup from a lost broadcast.
- Four entries dispatched out of age order and woken together by one tag, which tells oldest-first from slot-order selection and shows the width limit across two cycles.
- Each hold flag released separately, which shows that each flag gates issue on its own.
- Mixed memory, prefetch and plain entries under a cache stall.
- Squashes that hit waiting entries, an entry that is issuing in the same cycle, and a dispatch in the same cycle, which show that younger work is removed while older work is kept.
- A filled window, which shows the full flag and the dropped overflow dispatch.

// File: rtl/iq_pkg.sv
package iq_pkg;
    // Class flags carried with every entry; packed MSB first.
    typedef struct packed {
        logic is_mem;
        logic is_pref;
        logic nonspec;
        logic stcond;
        logic barrier;
        logic mdep_wait;
    } iq_cls_t;

    localparam int unsigned IQ_CLS_W = $bits(iq_cls_t);
endpackage

// File: rtl/iq_src_match.sv
module iq_src_match #(
    parameter int unsigned SEQ_W = 8,
    parameter int unsigned WB_N  = 2
) (
    input  logic [SEQ_W-1:0]           tag,
    input  logic                       rdy_in,
    input  logic [WB_N-1:0]            wb_valid,
    input  logic [WB_N-1:0][SEQ_W-1:0] wb_tag,
    output logic                       rdy_out
);
    always_comb begin
        rdy_out = rdy_in;
        for (int w = 0; w < int'(WB_N); w++) begin
            if (wb_valid[w] && (wb_tag[w] == tag)) begin
                rdy_out = 1'b1;
            end
        end
    end
endmodule

// File: rtl/iq_free_find.sv
module iq_free_find #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] busy,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = int'(DEPTH) - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/iq_age_select.sv
module iq_age_select #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned SEQ_W = 8,
    parameter int unsigned IW    = 2,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0]            elig,
    input  logic [DEPTH-1:0][SEQ_W-1:0] seq,
    output logic [IW-1:0]               lane_vld,
    output logic [IW-1:0][IDX_W-1:0]    lane_idx,
    output logic [DEPTH-1:0]            gnt
);
    logic [DEPTH-1:0] avail;
    logic             got;
    logic [IDX_W-1:0] best;

    always_comb begin
        avail    = elig;
        gnt      = '0;
        lane_vld = '0;
        lane_idx = '0;
        for (int l = 0; l < int'(IW); l++) begin
            got  = 1'b0;
            best = '0;
            for (int i = 0; i < int'(DEPTH); i++) begin
                if (avail[i] && (!got || (seq[i] < seq[best]))) begin
                    got  = 1'b1;
                    best = IDX_W'(i);
                end
            end
            lane_vld[l] = got;
            lane_idx[l] = best;
            if (got) begin
                avail[best] = 1'b0;
                gnt[best]   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/issue_queue.sv
module issue_queue
    import iq_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned SEQ_W = 8,
    parameter int unsigned NSRC  = 2,
    parameter int unsigned WB_N  = 2,
    parameter int unsigned IW    = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             dis_valid,
    input  logic [SEQ_W-1:0]                 dis_seq,
    input  logic [NSRC-1:0][SEQ_W-1:0]       dis_tag,
    input  logic [NSRC-1:0]                  dis_rdy,
    input  logic [5:0]                       dis_cls,
    output logic                             full,
    input  logic [WB_N-1:0]                  wb_valid,
    input  logic [WB_N-1:0][SEQ_W-1:0]       wb_tag,
    input  logic                             rel_valid,
    input  logic [SEQ_W-1:0]                 rel_seq,
    input  logic                             dc_stall,
    input  logic                             sq_valid,
    input  logic [SEQ_W-1:0]                 sq_seq,
    output logic [IW-1:0]                    iss_valid,
    output logic [IW-1:0][SEQ_W-1:0]         iss_seq,
    output logic [$clog2(DEPTH+1)-1:0]       wait_cnt,
    output logic [$clog2(DEPTH+1)-1:0]       mem_cnt
);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0]                       vld;
        logic [DEPTH-1:0][SEQ_W-1:0]            seq;
        logic [DEPTH-1:0][NSRC-1:0][SEQ_W-1:0]  tag;
        logic [DEPTH-1:0][NSRC-1:0]             rdy;
        iq_cls_t [DEPTH-1:0]                    cls;
    } iq_state_t;

    iq_state_t st_d, st_q;

    logic [DEPTH-1:0][NSRC-1:0] wk_rdy;
    logic [NSRC-1:0]            dis_wk_rdy;
    logic [DEPTH-1:0]           elig;
    logic [DEPTH-1:0]           gnt;
    logic [IW-1:0]              lane_vld;
    logic [IW-1:0][IDX_W-1:0]   lane_idx;
    logic                       free_found;
    logic [IDX_W-1:0]           free_idx;
    logic [CNT_W-1:0]           wait_c, mem_c;
    iq_cls_t                    in_cls;

    assign in_cls = iq_cls_t'(dis_cls);

    // Tag match for every stored source.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
        for (genvar gs = 0; gs < NSRC; gs++) begin : g_src
            iq_src_match #(.SEQ_W(SEQ_W), .WB_N(WB_N)) u_wk (
                .tag     (st_q.tag[gi][gs]),
                .rdy_in  (st_q.rdy[gi][gs]),
                .wb_valid(wb_valid),
                .wb_tag  (wb_tag),
                .rdy_out (wk_rdy[gi][gs])
            );
        end
    end

    // Tag match for the incoming entry: same-cycle broadcast is not lost.
    for (genvar gs = 0; gs < NSRC; gs++) begin : g_dsrc
        iq_src_match #(.SEQ_W(SEQ_W), .WB_N(WB_N)) u_dwk (
            .tag     (dis_tag[gs]),
            .rdy_in  (dis_rdy[gs]),
            .wb_valid(wb_valid),
            .wb_tag  (wb_tag),
            .rdy_out (dis_wk_rdy[gs])
        );
    end

    iq_free_find #(.DEPTH(DEPTH)) u_free (
        .busy (st_q.vld),
        .found(free_found),
        .idx  (free_idx)
    );

    // Eligibility from registered state.
    always_comb begin
        for (int i = 0; i < int'(DEPTH); i++) begin
            elig[i] = st_q.vld[i]
                    && (&st_q.rdy[i])
                    && !st_q.cls[i].nonspec
                    && !st_q.cls[i].stcond
                    && !st_q.cls[i].barrier
                    && !st_q.cls[i].mdep_wait
                    && !(dc_stall && st_q.cls[i].is_mem && !st_q.cls[i].is_pref)
                    && !(sq_valid && (st_q.seq[i] > sq_seq));
        end
    end

    iq_age_select #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .IW(IW)) u_sel (
        .elig    (elig),
        .seq     (st_q.seq),
        .lane_vld(lane_vld),
        .lane_idx(lane_idx),
        .gnt     (gnt)
    );

    // Next state and outputs.
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < int'(DEPTH); i++) begin
            st_d.rdy[i] = wk_rdy[i];
            if (rel_valid && st_q.vld[i] && (st_q.seq[i] == rel_seq)) begin
                st_d.cls[i].nonspec   = 1'b0;
                st_d.cls[i].stcond    = 1'b0;
                st_d.cls[i].barrier   = 1'b0;
                st_d.cls[i].mdep_wait = 1'b0;
            end
            if (gnt[i]) begin
                st_d.vld[i] = 1'b0;
            end
            if (sq_valid && (st_q.seq[i] > sq_seq)) begin
                st_d.vld[i] = 1'b0;
            end
        end
        if (dis_valid && free_found && !(sq_valid && (dis_seq > sq_seq))) begin
            st_d.vld[free_idx] = 1'b1;
            st_d.seq[free_idx] = dis_seq;
            st_d.tag[free_idx] = dis_tag;
            st_d.rdy[free_idx] = dis_wk_rdy;
            st_d.cls[free_idx] = in_cls;
        end

        wait_c = '0;
        mem_c  = '0;
        for (int i = 0; i < int'(DEPTH); i++) begin
            wait_c = wait_c + CNT_W'(st_q.vld[i]);
            mem_c  = mem_c + CNT_W'(st_q.vld[i] && st_q.cls[i].is_mem);
        end
        wait_cnt = wait_c;
        mem_cnt  = mem_c;
        full     = !free_found;

        for (int l = 0; l < int'(IW); l++) begin
            iss_valid[l] = lane_vld[l];
            iss_seq[l]   = lane_vld[l] ? st_q.seq[lane_idx[l]] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/issue_queue_sva.sv
module issue_queue_sva #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned SEQ_W = 8,
    parameter int unsigned IW    = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       dis_valid,
    input logic                       full,
    input logic                       sq_valid,
    input logic [SEQ_W-1:0]           sq_seq,
    input logic [IW-1:0]              iss_valid,
    input logic [IW-1:0][SEQ_W-1:0]   iss_seq,
    input logic [$clog2(DEPTH+1)-1:0] wait_cnt,
    input logic [$clog2(DEPTH+1)-1:0] mem_cnt
);
    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (wait_cnt == 0) && !full && (iss_valid == '0));

    a_r9_full_means_depth: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (int'(wait_cnt) == int'(DEPTH)));

    a_r9_full_drops_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
        (full && dis_valid && (iss_valid == '0) && !sq_valid) |=> (wait_cnt == $past(wait_cnt)));

    a_r2_one_dispatch_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (int'(wait_cnt) <= int'($past(wait_cnt)) + 1));

    a_r10_mem_within_wait: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cnt <= wait_cnt);

    for (genvar gl = 0; gl < IW; gl++) begin : g_lane
        a_r8_no_young_grant: assert property (@(posedge clk) disable iff (!rst_n)
            (sq_valid && iss_valid[gl]) |-> (iss_seq[gl] <= sq_seq));
        if (gl > 0) begin : g_ord
            a_r6_lane_order: assert property (@(posedge clk) disable iff (!rst_n)
                iss_valid[gl] |-> (iss_valid[gl-1] && (iss_seq[gl-1] < iss_seq[gl])));
        end
    end
endmodule

bind issue_queue issue_queue_sva #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .IW(IW)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .dis_valid(dis_valid),
    .full     (full),
    .sq_valid (sq_valid),
    .sq_seq   (sq_seq),
    .iss_valid(iss_valid),
    .iss_seq  (iss_seq),
    .wait_cnt (wait_cnt),
    .mem_cnt  (mem_cnt)
);

// File: tb/issue_queue_tb.sv
module issue_queue_tb;
    localparam int DEPTH = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             dis_valid = 1'b0;
    logic [7:0]       dis_seq = '0;
    logic [1:0][7:0]  dis_tag = '0;
    logic [1:0]       dis_rdy = '0;
    logic [5:0]       dis_cls = '0;
    logic             full;
    logic [1:0]       wb_valid = '0;
    logic [1:0][7:0]  wb_tag = '0;
    logic             rel_valid = 1'b0;
    logic [7:0]       rel_seq = '0;
    logic             dc_stall = 1'b0;
    logic             sq_valid = 1'b0;
    logic [7:0]       sq_seq = '0;
    logic [1:0]       iss_valid;
    logic [1:0][7:0]  iss_seq;
    logic [3:0]       wait_cnt;
    logic [3:0]       mem_cnt;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int exp_q[$];

    // class encodings, see R5
    localparam logic [5:0] C_PLAIN = 6'b000000;
    localparam logic [5:0] C_MEM   = 6'b100000;
    localparam logic [5:0] C_PREF  = 6'b110000;
    localparam logic [5:0] C_NSPEC = 6'b001000;
    localparam logic [5:0] C_STC   = 6'b000100;
    localparam logic [5:0] C_BAR   = 6'b000010;
    localparam logic [5:0] C_MDEP  = 6'b000001;

    issue_queue u_dut (
        .clk(clk), .rst_n(rst_n),
        .dis_valid(dis_valid), .dis_seq(dis_seq), .dis_tag(dis_tag),
        .dis_rdy(dis_rdy), .dis_cls(dis_cls), .full(full),
        .wb_valid(wb_valid), .wb_tag(wb_tag),
        .rel_valid(rel_valid), .rel_seq(rel_seq), .dc_stall(dc_stall),
        .sq_valid(sq_valid), .sq_seq(sq_seq),
        .iss_valid(iss_valid), .iss_seq(iss_seq),
        .wait_cnt(wait_cnt), .mem_cnt(mem_cnt)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: every grant is compared with the scoreboard front (R6 order).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int l = 0; l < 2; l++) begin
                if (iss_valid[l]) begin
                    if (exp_q.size() == 0) begin
                        n_cmp++;
                        n_bad++;
                        $display("FAIL R6 unexpected grant: actual %0d expected none", iss_seq[l]);
                    end else begin
                        chk("R6 grant order", int'(iss_seq[l]), exp_q.pop_front());
                    end
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic disp(input int s, input int t0, input bit r0,
                        input int t1, input bit r1, input logic [5:0] c);
        dis_valid  = 1'b1;
        dis_seq    = 8'(s);
        dis_tag[0] = 8'(t0);
        dis_tag[1] = 8'(t1);
        dis_rdy    = {r1, r0};
        dis_cls    = c;
        tick();
        dis_valid  = 1'b0;
    endtask

    task automatic wb1(input int t);
        wb_valid  = 2'b01;
        wb_tag[0] = 8'(t);
        tick();
        wb_valid  = 2'b00;
    endtask

    task automatic rel(input int s);
        rel_valid = 1'b1;
        rel_seq   = 8'(s);
        tick();
        rel_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1
        chk("R1 wait_cnt", int'(wait_cnt), 0);
        chk("R1 full", int'(full), 0);
        chk("R1 iss_valid", int'(iss_valid), 0);

        // R2: ready entry issues the cycle after dispatch
        exp_q.push_back(1);
        disp(1, 0, 1, 0, 1, C_PLAIN);
        chk("R2 waiting after dispatch", int'(wait_cnt), 1);
        tick();
        chk("R2 gone after grant", int'(wait_cnt), 0);

        // R3: two unready sources woken one at a time
        disp(10, 5, 0, 6, 0, C_PLAIN);
        tick();
        wb1(5);
        chk("R3 half woken not granted", int'(iss_valid), 0);
        exp_q.push_back(10);
        wb1(6);
        tick();
        chk("R3 drained", int'(wait_cnt), 0);

        // R4: same-cycle writeback and dispatch
        wb_valid  = 2'b10;
        wb_tag[1] = 8'd7;
        exp_q.push_back(20);
        disp(20, 7, 0, 0, 1, C_PLAIN);
        wb_valid  = 2'b00;
        chk("R4 woken at dispatch", int'(iss_valid), 1);
        tick();

        // R5: holds and release
        disp(30, 0, 1, 0, 1, C_NSPEC);
        disp(31, 0, 1, 0, 1, C_BAR);
        disp(32, 0, 1, 0, 1, C_STC);
        disp(33, 0, 1, 0, 1, C_MDEP);
        tick();
        chk("R5 held entries", int'(wait_cnt), 4);
        chk("R5 no grant while held", int'(iss_valid), 0);
        exp_q.push_back(31); rel(31);
        exp_q.push_back(33); rel(33);
        exp_q.push_back(30); rel(30);
        exp_q.push_back(32); rel(32);
        tick();
        chk("R5 all released", int'(wait_cnt), 0);

        // R6: out-of-order ages, width two
        disp(45, 99, 0, 0, 1, C_PLAIN);
        disp(42, 99, 0, 0, 1, C_PLAIN);
        disp(44, 99, 0, 0, 1, C_PLAIN);
        disp(41, 99, 0, 0, 1, C_PLAIN);
        exp_q.push_back(41); exp_q.push_back(42);
        exp_q.push_back(44); exp_q.push_back(45);
        wb1(99);
        chk("R6 two lanes", int'(iss_valid), 3);
        tick();
        tick();
        chk("R6 drained", int'(wait_cnt), 0);

        // R7: cache stall
        dc_stall = 1'b1;
        disp(50, 0, 1, 0, 1, C_MEM);
        exp_q.push_back(51);
        disp(51, 0, 1, 0, 1, C_PREF);
        exp_q.push_back(52);
        disp(52, 0, 1, 0, 1, C_PLAIN);
        tick();
        tick();
        chk("R7 load held under stall", int'(wait_cnt), 1);
        chk("R10 mem count under stall", int'(mem_cnt), 1);
        exp_q.push_back(50);
        dc_stall = 1'b0;
        tick();
        chk("R7 load drained", int'(wait_cnt), 0);

        // R8 / R10: squash waiting entries
        disp(60, 98, 0, 0, 1, C_MEM);
        disp(61, 98, 0, 0, 1, C_PLAIN);
        disp(62, 98, 0, 0, 1, C_MEM);
        disp(63, 98, 0, 0, 1, C_PLAIN);
        chk("R10 wait count", int'(wait_cnt), 4);
        chk("R10 mem count", int'(mem_cnt), 2);
        sq_valid = 1'b1;
        sq_seq   = 8'd61;
        exp_q.push_back(60); exp_q.push_back(61);
        wb1(98);
        sq_valid = 1'b0;
        chk("R8 younger removed", int'(wait_cnt), 2);
        chk("R8 mem count after squash", int'(mem_cnt), 1);
        tick();
        chk("R8 older drained", int'(wait_cnt), 0);

        // R8: squash hits an entry that is issuing now
        disp(70, 0, 1, 0, 1, C_PLAIN);
        sq_valid = 1'b1;
        sq_seq   = 8'd65;
        #1;
        chk("R8 squash cycle grant withheld", int'(iss_valid), 0);
        tick();
        sq_valid = 1'b0;
        chk("R8 squashed entry gone", int'(wait_cnt), 0);

        // R8: dispatch younger than boundary in squash cycle
        sq_valid = 1'b1;
        sq_seq   = 8'd75;
        disp(80, 0, 1, 0, 1, C_PLAIN);
        sq_valid = 1'b0;
        chk("R8 young dispatch dropped", int'(wait_cnt), 0);

        // R9: fill the window
        for (int k = 0; k < DEPTH; k++) begin
            disp(90 + k, 200, 0, 0, 1, C_PLAIN);
        end
        chk("R9 full", int'(full), 1);
        disp(98, 0, 1, 0, 1, C_PLAIN);
        chk("R9 overflow ignored", int'(wait_cnt), DEPTH);
        for (int k = 0; k < DEPTH; k++) exp_q.push_back(90 + k);
        wb1(200);
        repeat (4) tick();
        chk("R9 drained", int'(wait_cnt), 0);
        chk("R9 not full", int'(full), 0);
        repeat (2) tick();
        chk("R6 scoreboard empty", exp_q.size(), 0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule